// File: doc/BRIEF.md
# Crosspoint Configuration Controller

This block is the digital control logic for a 16-input, 8-output routing matrix. A host loads it through a four-wire serial port: serial clock, active-low chip select, data in and data out. A mode input picks one of two loading styles. Full-frame mode shifts in one 40-bit word that restages all eight outputs. Addressed mode shifts in 8-bit words, and each word restages one output. Both styles write into a staging register. The active routing changes only when a separate configure pulse arrives. In full-frame mode the staging register is a real shift register, so the bits that fall out of it appear on data out. Several devices can therefore be chained and loaded with one long stream.

Two active-high level inputs override the serial port. The reset override turns every output off. The broadcast override connects every output to input 0. The reset override wins when both are high. All serial, configure and override inputs are synchronised to the system clock. The serial clock is treated as a sampled signal, and its rising edges are found in the system clock domain. For each output the block produces a 4-bit selected input address and an enable.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `rst_ni` is low, every `en_o` bit is 0, every `sel_o` field is 0 and `sdo_o` is 0.
- R2: With `mode_i` = 0, each rising `sclk_i` while `csn_i` is low shifts in `sdi_i`, and the first bit shifted becomes frame bit 0. After 40 bits, output n is set from frame bits 5n..5n+4. Bits 5n..5n+3 are the input address, with bit 5n as the LSB. Bit 5n+4 is the off bit: 1 means disabled (`en_o[n]` = 0) and 0 means enabled.
- R3: In full-frame mode each shift puts on `sdo_o` the bit that left the staging register. A second frame therefore emits the previous frame on `sdo_o`, bit 0 first.
- R4: With `mode_i` = 1, each group of 8 bits forms one word, and bit 0 is shifted first. Bits 0-2 are the output address, bits 3-6 are the input address (LSB first) and bit 7 is the off bit. The word changes the staged setting of that output only. Several words may be sent in one chip-select window. `sdo_o` does not change in this mode.
- R5: Active outputs change only on a rising edge of `cfg_i`. That edge copies all staged settings to the active registers, and staged changes stay invisible until then.
- R6: While `csn_i` is high, `sclk_i` edges are ignored. The staged settings and `sdo_o` are kept.
- R7: While `ovr_rst_i` is high, the staged and active settings of all outputs are input 0 with the output off. A `cfg_i` edge in that time has no effect. After release, a configure pulse still yields all outputs off.
- R8: While `bcst_i` is high (and `ovr_rst_i` is low), the staged and active settings of all outputs are input 0 with the output on.
- R9: When `ovr_rst_i` and `bcst_i` are both high, all outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled |
| csn_i | input | 1 | Serial chip select, active low |
| sdi_i | input | 1 | Serial data in |
| mode_i | input | 1 | 0 full-frame, 1 addressed |
| cfg_i | input | 1 | Configure: rising edge commits staged settings |
| ovr_rst_i | input | 1 | Active-high override turning all outputs off |
| bcst_i | input | 1 | Active-high override routing input 0 to all outputs |
| sdo_o | output | 1 | Serial data out, bit last shifted out |
| sel_o | output | 32 | Selected input address, 4 bits per output, output n at [4n+3:4n] |
| en_o | output | 8 | Output enable, one per output |

## Verification
The bench checks the bit order of a frame against the slot layout. A design that shifted the wrong way or mapped slots backwards would route outputs to mirrored addresses. It sends a second frame and compares `sdo_o` with the first one bit by bit. This catches a register that drops or reorders chained bits. Addressed words are sent two in one select window and with the off bit set, which exposes word counters that do not wrap and writes that touch neighbouring outputs. The bench raises both overrides together, pulses configure during the reset override, and toggles the serial clock with chip select high. A wrong priority, a leaky commit path or a missing select gate would each show up as changed outputs.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  typedef enum logic {
    LOAD_FRAME = 1'b0,
    LOAD_ADDR  = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_cfg_sync.sv
module xpt_cfg_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xpt_cfg_serial.sv
module xpt_cfg_serial
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned FRAME_W = N_OUT * (SEL_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               sdi_i,
  input  logic               mode_i,
  input  logic               ovr_rst_i,
  input  logic               bcst_i,
  output logic [FRAME_W-1:0] stage_o,
  output logic               sdo_o
);
  localparam int unsigned ADDR_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int unsigned SLOT_W = SEL_W + 1;
  localparam int unsigned WORD_W = ADDR_W + SEL_W + 1;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam logic [FRAME_W-1:0] OFF_FRAME = {N_OUT{{1'b1, {SEL_W{1'b0}}}}};
  localparam logic [FRAME_W-1:0] ON_FRAME  = '0;

  load_mode_e         mode;
  logic               sclk_d_q;
  logic               shift;
  logic [FRAME_W-1:0] stage_q, stage_nxt;
  logic [WORD_W-1:0]  word_q, word_nxt;
  logic [CNT_W-1:0]   cnt_q;
  logic               word_done;
  logic [ADDR_W-1:0]  w_addr;
  logic [SLOT_W-1:0]  w_slot;
  logic               sdo_q;

  assign mode      = load_mode_e'(mode_i);
  assign shift     = sclk_i & ~sclk_d_q & ~csn_i;
  assign word_nxt  = {sdi_i, word_q[WORD_W-1:1]};
  assign word_done = shift && (mode == LOAD_ADDR) && (cnt_q == CNT_W'(WORD_W - 1));
  assign w_addr    = word_nxt[ADDR_W-1:0];
  assign w_slot    = {word_nxt[WORD_W-1], word_nxt[ADDR_W +: SEL_W]};

  always_comb begin
    stage_nxt = stage_q;
    if (shift && mode == LOAD_FRAME) begin
      stage_nxt = {sdi_i, stage_q[FRAME_W-1:1]};
    end else if (word_done) begin
      for (int n = 0; n < N_OUT; n++)
        if (w_addr == ADDR_W'(n)) stage_nxt[n*SLOT_W +: SLOT_W] = w_slot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= OFF_FRAME;
      word_q  <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else if (ovr_rst_i) begin
      stage_q <= OFF_FRAME;
      cnt_q   <= '0;
    end else if (bcst_i) begin
      stage_q <= ON_FRAME;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_nxt;
      if (csn_i || mode == LOAD_FRAME) begin
        cnt_q <= '0;
      end else if (shift) begin
        cnt_q  <= (cnt_q == CNT_W'(WORD_W - 1)) ? '0 : cnt_q + 1'b1;
        word_q <= word_nxt;
      end
      if (shift && mode == LOAD_FRAME) sdo_q <= stage_q[0];
    end
  end

  assign stage_o = stage_q;
  assign sdo_o   = sdo_q;

  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && !ovr_rst_i && !bcst_i) |=> $stable(stage_q)) else $error("stage moved with select high"); // R6
  AST_CS_SDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> $stable(sdo_q)) else $error("sdo moved with select high"); // R6
  AST_ADDR_SDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == LOAD_ADDR) |=> $stable(sdo_q)) else $error("sdo moved in addressed mode"); // R4
  AST_CHAIN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && mode == LOAD_FRAME && !ovr_rst_i && !bcst_i) |=> (sdo_q == $past(stage_q[0])))
    else $error("chained bit lost"); // R3
  AST_OVR_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_rst_i |=> (stage_q == OFF_FRAME)) else $error("override reset did not clear stage"); // R7
endmodule

// File: rtl/xpt_cfg_active.sv
module xpt_cfg_active #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned FRAME_W = N_OUT * (SEL_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [FRAME_W-1:0]     stage_i,
  input  logic                   cfg_i,
  input  logic                   ovr_rst_i,
  input  logic                   bcst_i,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o
);
  localparam int unsigned SLOT_W = SEL_W + 1;
  localparam logic [FRAME_W-1:0] OFF_FRAME = {N_OUT{{1'b1, {SEL_W{1'b0}}}}};

  logic               cfg_d_q;
  logic               cfg_rise;
  logic [FRAME_W-1:0] act_q;

  assign cfg_rise = cfg_i & ~cfg_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_d_q <= 1'b0;
      act_q   <= OFF_FRAME;
    end else begin
      cfg_d_q <= cfg_i;
      if (ovr_rst_i)     act_q <= OFF_FRAME;
      else if (bcst_i)   act_q <= '0;
      else if (cfg_rise) act_q <= stage_i;
    end
  end

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    assign sel_o[n*SEL_W +: SEL_W] = act_q[n*SLOT_W +: SEL_W];
    assign en_o[n]                 = ~act_q[n*SLOT_W + SEL_W];
  end

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rise && !ovr_rst_i && !bcst_i) |=> $stable(act_q)) else $error("active changed without commit"); // R5
  AST_CFG_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rise && !ovr_rst_i && !bcst_i) |=> (act_q == $past(stage_i))) else $error("commit lost data"); // R5
  AST_BCST_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcst_i && !ovr_rst_i) |=> (en_o == '1 && sel_o == '0)) else $error("broadcast not applied"); // R8
  AST_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_rst_i |=> (en_o == '0 && sel_o == '0)) else $error("override reset lost priority"); // R9
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl #(
  parameter int unsigned N_IN        = 16,
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   csn_i,
  input  logic                   sdi_i,
  input  logic                   mode_i,
  input  logic                   cfg_i,
  input  logic                   ovr_rst_i,
  input  logic                   bcst_i,
  output logic                   sdo_o,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o
);
  localparam int unsigned FRAME_W = N_OUT * (SEL_W + 1);
  // sync bit order: {bcst, ovr_rst, cfg, mode, sdi, csn, sclk}; csn idles high
  localparam logic [6:0] SYNC_RST = 7'b000_0010;

  logic [6:0]         raw, syn;
  logic [FRAME_W-1:0] stage;

  assign raw = {bcst_i, ovr_rst_i, cfg_i, mode_i, sdi_i, csn_i, sclk_i};

  xpt_cfg_sync #(.W(7), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  xpt_cfg_serial #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_serial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (syn[0]),
    .csn_i    (syn[1]),
    .sdi_i    (syn[2]),
    .mode_i   (syn[3]),
    .ovr_rst_i(syn[5]),
    .bcst_i   (syn[6]),
    .stage_o  (stage),
    .sdo_o    (sdo_o)
  );

  xpt_cfg_active #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stage_i  (stage),
    .cfg_i    (syn[4]),
    .ovr_rst_i(syn[5]),
    .bcst_i   (syn[6]),
    .sel_o    (sel_o),
    .en_o     (en_o)
  );
endmodule

// File: tb/xpt_cfg_ctrl_tb.sv
module xpt_cfg_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] OFF_ALL = {8{5'b10000}};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0, mode = 1'b0;
  logic        cfg = 1'b0, ovr_rst = 1'b0, bcst = 1'b0;
  logic        sdo;
  logic [31:0] sel;
  logic [7:0]  en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [39:0] exp_stage, exp_act, cap;
  logic [31:0] q_sel[$];
  logic [7:0]  q_en[$];
  string       q_tag[$];
  int          pending = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_cfg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .mode_i(mode), .cfg_i(cfg), .ovr_rst_i(ovr_rst), .bcst_i(bcst),
    .sdo_o(sdo), .sel_o(sel), .en_o(en)
  );

  function automatic logic [31:0] dec_sel(logic [39:0] f);
    logic [31:0] s;
    for (int n = 0; n < 8; n++) s[n*4 +: 4] = f[n*5 +: 4];
    return s;
  endfunction

  function automatic logic [7:0] dec_en(logic [39:0] f);
    logic [7:0] e;
    for (int n = 0; n < 8; n++) e[n] = ~f[n*5 + 4];
    return e;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_out(logic [39:0] f, string tag);
    q_sel.push_back(dec_sel(f));
    q_en.push_back(dec_en(f));
    q_tag.push_back(tag);
    pending++;
    wait (pending == 0);
    @(negedge clk);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      wait (pending > 0);
      wait_clk(6);
      checks++;
      if (sel !== q_sel[0] || en !== q_en[0]) begin
        fails++;
        $display("FAIL %s: sel=%h en=%h expected sel=%h en=%h",
                 q_tag[0], sel, en, q_sel[0], q_en[0]);
      end
      void'(q_sel.pop_front());
      void'(q_en.pop_front());
      void'(q_tag.pop_front());
      pending--;
    end
  end

  task automatic check_val(logic [39:0] got, logic [39:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sclk_bit(logic b);
    sdi = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send_frame(logic [39:0] f);
    mode = 1'b0;
    csn  = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 40; i++) begin
      sclk_bit(f[i]);
      cap[i] = sdo;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(4);
    exp_stage = f;
  endtask

  task automatic send_word(logic [2:0] a, logic [3:0] s, logic off);
    logic [7:0] w;
    w = {off, s, a};
    for (int i = 0; i < 8; i++) sclk_bit(w[i]);
    exp_stage[a*5 +: 5] = {off, s};
  endtask

  task automatic pulse_cfg();
    cfg = 1'b1;
    wait_clk(4);
    cfg = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] f1, f2;
    logic        sdo_before;
    f1 = 40'hA5_3C_96_E1_7B;
    f2 = 40'h1E_D2_47_8F_C6;
    exp_stage = OFF_ALL;
    exp_act   = OFF_ALL;

    wait_clk(5);
    expect_out(OFF_ALL, "R1 reset outputs");
    check_val({39'd0, sdo}, 40'd0, "R1 reset sdo");
    rst_ni = 1'b1;
    wait_clk(4);

    send_frame(f1);
    expect_out(exp_act, "R5 frame staged only");
    pulse_cfg();
    exp_act = exp_stage;
    expect_out(exp_act, "R2 frame applied");

    send_frame(f2);
    check_val(cap, f1, "R3 chained data out");
    expect_out(exp_act, "R5 second frame staged only");

    sdo_before = sdo;
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    check_val({39'd0, sdo}, {39'd0, sdo_before}, "R6 sdo held with select high");
    pulse_cfg();
    exp_act = exp_stage;
    expect_out(exp_act, "R6 stage held with select high");

    sdo_before = sdo;
    mode = 1'b1;
    csn  = 1'b0;
    wait_clk(2);
    send_word(3'd5, 4'd9, 1'b0);
    send_word(3'd0, 4'd14, 1'b1);
    wait_clk(4);
    csn = 1'b1;
    wait_clk(4);
    check_val({39'd0, sdo}, {39'd0, sdo_before}, "R4 sdo quiet in addressed mode");
    expect_out(exp_act, "R5 addressed words staged only");
    pulse_cfg();
    exp_act = exp_stage;
    expect_out(exp_act, "R4 two addressed words applied");

    bcst = 1'b1;
    exp_stage = '0;
    exp_act   = '0;
    expect_out(exp_act, "R8 broadcast active");
    bcst = 1'b0;
    wait_clk(4);
    pulse_cfg();
    expect_out(exp_act, "R8 broadcast staged");

    csn = 1'b0;
    wait_clk(2);
    send_word(3'd2, 4'd3, 1'b0);
    send_word(3'd7, 4'd15, 1'b1);
    wait_clk(4);
    csn = 1'b1;
    wait_clk(4);
    pulse_cfg();
    exp_act = exp_stage;
    expect_out(exp_act, "R4 single output updates");

    ovr_rst = 1'b1;
    bcst    = 1'b1;
    exp_stage = OFF_ALL;
    exp_act   = OFF_ALL;
    expect_out(exp_act, "R9 reset over broadcast");
    bcst = 1'b0;
    wait_clk(4);
    pulse_cfg();
    expect_out(exp_act, "R7 configure ignored in reset");
    ovr_rst = 1'b0;
    wait_clk(4);
    pulse_cfg();
    expect_out(exp_act, "R7 staged cleared by reset");

    send_frame(f1);
    pulse_cfg();
    exp_act = exp_stage;
    expect_out(exp_act, "R2 frame after override");
    rst_ni = 1'b0;
    wait_clk(2);
    exp_act = OFF_ALL;
    expect_out(exp_act, "R1 reset clears active");
    check_val({39'd0, sdo}, 40'd0, "R1 reset clears sdo");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule